// File: doc/BRIEF.md
# Converter Wake-Up Sequencer

This block governs how the digital path of an audio converter leaves and re-enters power-down. An asynchronous active-low power-down pin is brought into the master clock domain and filtered, so that brief low glitches are ignored. A sustained low is treated as a real power-down request. While the request is active, the decimation filter is held in reset and the output samples are forced to zero.

When the pin returns high, the block waits a fixed number of master clock cycles for the internal supplies. In slave mode it then also waits for the next rising edge of the frame clock. After that it releases the filter reset and counts frame-clock periods of initialization. The frame count is different for master and slave operation. Only when that count ends does the zero-forcing stop and the data-valid flag rise. A new power-down request at any point throws the sequence back to its start.

Top module: `adc_wake_seq`

## Requirements
- R1: While the asynchronous reset is applied, and right after it, filt_rst_o is 1, zero_force_o is 1 and data_valid_o is 0.
- R2: A low on pwr_down_n_i seen for fewer than GLITCH_CYC consecutive master clock samples has no effect: data_valid_o stays 1 and filt_rst_o stays 0.
- R3: A low seen for GLITCH_CYC or more consecutive samples puts the block in power-down: filt_rst_o goes to 1, zero_force_o to 1 and data_valid_o to 0.
- R4: In master mode (master_mode_i = 1), filt_rst_o falls PWRUP_CYC + 4 master clocks after pwr_down_n_i returns high. This delay is made of two synchronizer stages, one filter stage, one state stage and the power-up count.
- R5: In slave mode (master_mode_i = 0), after the power-up count, filt_rst_o falls only after a rising edge of frame_clk_i, 3 master clocks behind that edge.
- R6: data_valid_o rises on the INIT_MASTER-th frame-clock rising edge after the filter-reset release in master mode, and on the INIT_SLAVE-th edge in slave mode.
- R7: zero_force_o is 1 whenever data_valid_o is 0, through power-down and through initialization.
- R8: A power-down request during initialization restarts the whole sequence: data_valid_o does not rise, filt_rst_o returns to 1, and the full wake-up delay is counted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_down_n_i | input | 1 | Asynchronous power-down pin, active low |
| frame_clk_i | input | 1 | Frame (word select) clock, synchronous to mclk_i |
| master_mode_i | input | 1 | 1 = master timing, 0 = slave timing |
| filt_rst_o | output | 1 | Reset for the decimation filter |
| zero_force_o | output | 1 | Forces both output channels to zero |
| data_valid_o | output | 1 | Output samples are valid |

## Verification
Some internal faults show up only at the next wake-up. A wrong glitch count shows as a stray filter reset, or a missing one, within about GLITCH_CYC + 4 master clocks of the pulse. A miscounted power-up delay moves the fall of filt_rst_o by that exact number of cycles. A wrong frame target or a wrong mode choice changes how many frame edges lie between the filter release and the rise of data_valid_o. A lost restart shows as data_valid_o rising too early after a mid-initialization request.

// File: rtl/adc_wake_pkg.sv
package adc_wake_pkg;
  typedef enum logic [2:0] {
    ST_PD    = 3'd0,
    ST_WAKE  = 3'd1,
    ST_ALIGN = 3'd2,
    ST_INIT  = 3'd3,
    ST_RUN   = 3'd4
  } wake_state_e;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= RST_VAL;
        else if (i == 0) stage_q[i] <= d_i;
        else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pd_glitch_filter.sv
module pd_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  output logic pd_req_o
);
  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam logic [GW-1:0] LIMIT = GW'(GLITCH_CYC);

  logic          pin_s;
  logic [GW-1:0] low_cnt_q, low_cnt_d;

  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_n_i),
    .q_o   (pin_s)
  );

  always_comb begin
    low_cnt_d = low_cnt_q;
    if (pin_s) low_cnt_d = '0;
    else if (low_cnt_q != LIMIT) low_cnt_d = low_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_cnt_q <= LIMIT;
    else low_cnt_q <= low_cnt_d;
  end

  assign pd_req_o = (low_cnt_q == LIMIT);

  // R2: a request may only appear after the synchronized pin was low
  p_glitch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_req_o) |-> $past(!pin_s));
  // R2: the run-length counter never passes its limit
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt_q <= LIMIT);
endmodule

// File: rtl/frame_rise_det.sv
module frame_rise_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic rise_o
);
  logic frame_s, frame_prev_q;

  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (frame_i),
    .q_o   (frame_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_prev_q <= 1'b0;
    else frame_prev_q <= frame_s;
  end

  assign rise_o = frame_s & ~frame_prev_q;

  // R5: one pulse per frame-clock rising edge
  p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/adc_wake_seq.sv
module adc_wake_seq
  import adc_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 4,
  parameter int PWRUP_CYC   = 147456,
  parameter int INIT_MASTER = 4129,
  parameter int INIT_SLAVE  = 4132
) (
  input  logic mclk_i,
  input  logic rst_ni,
  input  logic pwr_down_n_i,
  input  logic frame_clk_i,
  input  logic master_mode_i,
  output logic filt_rst_o,
  output logic zero_force_o,
  output logic data_valid_o
);
  localparam int MAXI   = (INIT_MASTER > INIT_SLAVE) ? INIT_MASTER : INIT_SLAVE;
  localparam int MAXC   = (PWRUP_CYC > MAXI) ? PWRUP_CYC : MAXI;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(PWRUP_CYC - 1);
  localparam logic [CW-1:0] INIT_M_LAST = CW'(INIT_MASTER - 1);
  localparam logic [CW-1:0] INIT_S_LAST = CW'(INIT_SLAVE - 1);

  wake_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pd_req, frame_rise;
  logic [CW-1:0] init_last;

  pd_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk_i   (mclk_i),
    .rst_ni  (rst_ni),
    .pin_n_i (pwr_down_n_i),
    .pd_req_o(pd_req)
  );

  frame_rise_det #(.SYNC_STAGES(SYNC_STAGES)) u_frame (
    .clk_i  (mclk_i),
    .rst_ni (rst_ni),
    .frame_i(frame_clk_i),
    .rise_o (frame_rise)
  );

  assign init_last = master_mode_i ? INIT_M_LAST : INIT_S_LAST;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_PD: begin
        cnt_d = '0;
        if (!pd_req) state_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (cnt_q == WAKE_LAST) begin
          cnt_d   = '0;
          state_d = master_mode_i ? ST_INIT : ST_ALIGN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ALIGN: begin
        cnt_d = '0;
        if (frame_rise) state_d = ST_INIT;
      end
      ST_INIT: begin
        if (frame_rise) begin
          if (cnt_q >= init_last) state_d = ST_RUN;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RUN: state_d = ST_RUN;
      default: state_d = ST_PD;
    endcase
    if (pd_req) begin
      state_d = ST_PD;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign filt_rst_o   = (state_q == ST_PD) || (state_q == ST_WAKE) || (state_q == ST_ALIGN);
  assign data_valid_o = (state_q == ST_RUN);
  assign zero_force_o = (state_q != ST_RUN);

  // R3: a filtered request forces reset and invalid data on the next cycle
  p_pd_forces_r3: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    pd_req |=> (filt_rst_o && !data_valid_o));
  // R4: the power-up counter stays inside its window
  p_wake_bound_r4: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE) |-> (cnt_q <= WAKE_LAST));
  // R5: in slave timing the filter release follows a frame edge
  p_slave_align_r5: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    ($fell(filt_rst_o) && !$past(master_mode_i)) |-> $past(frame_rise));
  // R6: valid data only ever starts from initialization on a frame edge
  p_valid_from_init_r6: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    $rose(data_valid_o) |-> ($past(state_q == ST_INIT) && $past(frame_rise)));
endmodule

// File: tb/adc_wake_seq_tb.sv
module adc_wake_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GLITCH = 4;
  localparam int PWRUP  = 40;
  localparam int INIT_M = 9;
  localparam int INIT_S = 12;
  localparam int FRAME_HALF = 8;
  localparam int NVEC = 6;
  // vector: mode (1 = master), low length in master clocks, reset expected
  localparam int VEC_MODE [NVEC] = '{1, 1, 0, 0, 1, 0};
  localparam int VEC_LEN  [NVEC] = '{GLITCH-1, GLITCH, 1, GLITCH+5, 12, GLITCH-1};
  localparam int VEC_EXP  [NVEC] = '{0, 1, 0, 1, 1, 0};

  logic clk = 1'b0;
  logic rst_n, pin_n, frame, mode;
  logic filt_rst, zero_f, valid;
  int   checks = 0, fails = 0;
  int   cyc = 0, frame_rises = 0, last_rise_cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_wake_seq #(
    .GLITCH_CYC(GLITCH), .PWRUP_CYC(PWRUP),
    .INIT_MASTER(INIT_M), .INIT_SLAVE(INIT_S)
  ) u_dut (
    .mclk_i(clk), .rst_ni(rst_n), .pwr_down_n_i(pin_n),
    .frame_clk_i(frame), .master_mode_i(mode),
    .filt_rst_o(filt_rst), .zero_force_o(zero_f), .data_valid_o(valid)
  );

  // frame clock and cycle counter, driven just after each rising edge
  initial begin
    int ph = 0;
    frame = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      ph++;
      if (ph == FRAME_HALF) begin
        ph = 0;
        frame = ~frame;
        if (frame) begin
          frame_rises++;
          last_rise_cyc = cyc;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic low_pulse(input int len);
    @(negedge clk);
    pin_n = 1'b0;
    repeat (len) @(negedge clk);
    pin_n = 1'b1;
  endtask

  // follow one wake-up from the pin going high; returns measured values
  task automatic measure(output int wake, output int edges, output int align, output bit ok);
    int high_cyc, fall_cyc, r0;
    bit seen_rst = 0, fell = 0;
    high_cyc = cyc;
    ok = 0; wake = -1; edges = -1; align = -1; r0 = 0; fall_cyc = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (filt_rst) seen_rst = 1;
      if (valid == zero_f) check(0, "R7", zero_f, !valid);
      if (seen_rst && !fell && !filt_rst) begin
        fell = 1; fall_cyc = cyc; r0 = frame_rises;
        wake = fall_cyc - high_cyc;
        align = fall_cyc - last_rise_cyc;
      end
      if (fell && valid) begin
        edges = frame_rises - r0;
        ok = 1;
        break;
      end
    end
  endtask

  task automatic check_wake(input int m, input int wake, input int edges, input int align);
    if (m == 1) begin
      check(wake >= PWRUP + 3 && wake <= PWRUP + 5, "R4", wake, PWRUP + 4);
      check(edges == INIT_M || edges == INIT_M - 1, "R6", edges, INIT_M);
    end else begin
      check(wake >= PWRUP + 4, "R5", wake, PWRUP + 4);
      check(align == 3, "R5", align, 3);
      check(edges == INIT_S, "R6", edges, INIT_S);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int wake, edges, align;
    bit ok, bad;
    rst_n = 1'b0; pin_n = 1'b1; mode = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(filt_rst === 1'b1, "R1", filt_rst, 1);
    check(zero_f === 1'b1, "R1", zero_f, 1);
    check(valid === 1'b0, "R1", valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(filt_rst && zero_f && !valid, "R1", valid, 0);
    measure(wake, edges, align, ok);
    check(ok, "R6", ok, 1);

    for (int v = 0; v < NVEC; v++) begin
      mode = VEC_MODE[v][0];
      repeat (5) @(negedge clk);
      low_pulse(VEC_LEN[v]);
      if (VEC_EXP[v] == 1) begin
        measure(wake, edges, align, ok);
        check(ok, "R3", ok, 1);
        check_wake(VEC_MODE[v], wake, edges, align);
      end else begin
        bad = 0;
        for (int i = 0; i < 40; i++) begin
          @(negedge clk);
          if (filt_rst || !valid) bad = 1;
        end
        check(!bad, "R2", bad, 0);
      end
    end

    // R3: a held low keeps power-down state
    mode = 1'b1;
    @(negedge clk);
    pin_n = 1'b0;
    repeat (GLITCH + 6) @(negedge clk);
    check(filt_rst && zero_f && !valid, "R3", valid, 0);
    pin_n = 1'b1;
    measure(wake, edges, align, ok);
    check_wake(1, wake, edges, align);

    // R8: request during initialization restarts everything
    low_pulse(GLITCH + 2);
    bad = 0;
    for (int i = 0; i < PWRUP + 4 + 3 * 2 * FRAME_HALF; i++) begin
      @(negedge clk);
      if (valid) bad = 1;
    end
    check(!bad && !filt_rst, "R8", bad, 0);
    low_pulse(GLITCH + 2);
    measure(wake, edges, align, ok);
    check(ok, "R8", ok, 1);
    check(wake >= PWRUP + 3 && wake <= PWRUP + 5, "R8", wake, PWRUP + 4);
    check(edges == INIT_M || edges == INIT_M - 1, "R8", edges, INIT_M);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule